// File: doc/BRIEF.md
# DMA Burst Wrap Address Generator

This block produces the address sequence for one side (read or write) of a DMA channel. On channel start it copies a begin address into both a held base pointer and the live address. From then on it steps the address by a signed per-word increment inside a burst, and by a signed between-burst increment at each burst end.

A 16-bit wrap counter counts bursts down. The burst that ends with the counter at zero does not step linearly. Instead it moves the base pointer by a signed wrap increment and restarts the live address from the new base. The counter is then reloaded from the wrap size register. A wrap size of N therefore gives a wrap every N+1 bursts.

If the wrap size is larger than the programmed transfer size when the channel starts, wrapping is switched off for that run. The wrap size register can only be written while a protection enable is held. The wrap counter is readable at all times, so after a halt it shows how many bursts were left.

Top module: `wrapAddrGen`

## Requirements
- R1: After reset the address output, the wrap size register and the wrap counter all read zero.
- R2: A wrap size write takes effect on the next clock only if the write strobe and the protection enable are both high. A write strobe without protection leaves the register unchanged.
- R3: A start pulse loads the address output with the begin address input and loads the wrap counter with the wrap size register value, both visible one clock later.
- R4: A word strobe without a burst end moves the address by the sign-extended burst step. Negative steps count down.
- R5: With wrapping enabled, a burst end at a nonzero counter moves the address by the sign-extended transfer step and decrements the counter by one.
- R6: With wrapping enabled, a burst end at counter zero adds the sign-extended wrap step to the base pointer and loads the address with the new base. It also reloads the counter from the wrap size register. A wrap size of N gives a wrap after every N+1 bursts.
- R7: If the wrap size exceeds the transfer size at start, wrapping is off for that run. The counter holds its start value and every burst end steps the address linearly. Equal values leave wrapping on.
- R8: The wrap counter changes only on a start or a burst end. On idle or word-only cycles it holds, so its value after a halt shows the bursts left.
- R9: A start overrides a burst end or word strobe in the same cycle. A burst end overrides a word strobe in the same cycle.
- R10: The full 16-bit range works: a wrap size of 0xFFFF, with an equal transfer size, loads 0xFFFF into the counter and decrements it to 0xFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Channel start pulse |
| wordAdv | input | 1 | A word inside the burst was moved |
| burstEnd | input | 1 | Last word of a burst was moved |
| regWrEn | input | 1 | Wrap size register write strobe |
| regProtEn | input | 1 | Protection enable for register writes |
| regWrData | input | CNT_W | Write data for the wrap size register |
| beginAddr | input | ADDR_W | Begin address loaded at start |
| burstStep | input | STEP_W | Signed step per word within a burst |
| xferStep | input | STEP_W | Signed step between bursts |
| wrapStep | input | STEP_W | Signed step applied to the base on wrap |
| xferSize | input | CNT_W | Transfer length in bursts minus one |
| addrOut | output | ADDR_W | Current address |
| wrapSizeQ | output | CNT_W | Wrap size register readback |
| wrapCountQ | output | CNT_W | Live wrap counter |

## Verification
A wrong counter value shows up at `wrapCountQ` on the clock after the burst end that caused it. On the burst where the counter should reach zero, the address then jumps to the wrong place, so the error also reaches `addrOut` within one wrap period. A corrupted base pointer is only seen at the next wrap, when the address restarts from the wrong base. For that reason the bench runs several full wrap periods with both positive and negative steps. A disable flag latched wrongly shows up as a counter that moves when it should hold, or holds when it should move, on the first burst end after start.

// File: rtl/wag_pkg.sv
package wag_pkg;
  typedef struct packed {
    logic loadStart;
    logic stepWord;
    logic stepXfer;
    logic doWrap;
  } wagStrobeT;
endpackage

// File: rtl/wagSext.sv
module wagSext #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  inVal,
  output logic [OUT_W-1:0] outVal
);
  localparam int PAD = OUT_W - IN_W;
  generate
    if (PAD > 0) begin : gWiden
      assign outVal = {{PAD{inVal[IN_W-1]}}, inVal};
    end else begin : gTrim
      assign outVal = inVal[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/wagCtrl.sv
module wagCtrl
  import wag_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             wordAdv,
  input  logic             burstEnd,
  input  logic             regWrEn,
  input  logic             regProtEn,
  input  logic [CNT_W-1:0] regWrData,
  input  logic [CNT_W-1:0] xferSize,
  output wagStrobeT        strb,
  output logic [CNT_W-1:0] wrapSizeQ,
  output logic [CNT_W-1:0] wrapCountQ
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] sizeReg;
  logic [CNT_W-1:0] cntReg;
  logic             wrapOn;
  logic             sizeWrOk;
  logic             cntAtZero;
  logic             wrapDue;

  assign sizeWrOk  = regWrEn & regProtEn;
  assign cntAtZero = (cntReg == CNT_ZERO);
  assign wrapDue   = wrapOn & cntAtZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sizeReg <= '0;
    end else if (sizeWrOk) begin
      sizeReg <= regWrData;
    end
  end

  always_comb begin
    strb           = '0;
    strb.loadStart = start;
    strb.doWrap    = !start && burstEnd && wrapDue;
    strb.stepXfer  = !start && burstEnd && !wrapDue;
    strb.stepWord  = !start && !burstEnd && wordAdv;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntReg <= '0;
      wrapOn <= 1'b0;
    end else if (start) begin
      cntReg <= sizeReg;
      wrapOn <= !(sizeReg > xferSize);
    end else if (burstEnd && wrapOn) begin
      cntReg <= cntAtZero ? sizeReg : (cntReg - CNT_ONE);
    end
  end

  assign wrapSizeQ  = sizeReg;
  assign wrapCountQ = cntReg;
endmodule

// File: rtl/wagDatapath.sv
module wagDatapath
  import wag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STEP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  wagStrobeT         strb,
  input  logic [ADDR_W-1:0] beginAddr,
  input  logic [STEP_W-1:0] burstStep,
  input  logic [STEP_W-1:0] xferStep,
  input  logic [STEP_W-1:0] wrapStep,
  output logic [ADDR_W-1:0] addrOut
);
  logic [ADDR_W-1:0] basePtr;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] burstExt;
  logic [ADDR_W-1:0] xferExt;
  logic [ADDR_W-1:0] wrapExt;
  logic [ADDR_W-1:0] nextBase;

  wagSext #(.IN_W(STEP_W), .OUT_W(ADDR_W)) uExtBurst (.inVal(burstStep), .outVal(burstExt));
  wagSext #(.IN_W(STEP_W), .OUT_W(ADDR_W)) uExtXfer  (.inVal(xferStep),  .outVal(xferExt));
  wagSext #(.IN_W(STEP_W), .OUT_W(ADDR_W)) uExtWrap  (.inVal(wrapStep),  .outVal(wrapExt));

  assign nextBase = basePtr + wrapExt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      basePtr <= '0;
      curAddr <= '0;
    end else if (strb.loadStart) begin
      basePtr <= beginAddr;
      curAddr <= beginAddr;
    end else if (strb.doWrap) begin
      basePtr <= nextBase;
      curAddr <= nextBase;
    end else if (strb.stepXfer) begin
      curAddr <= curAddr + xferExt;
    end else if (strb.stepWord) begin
      curAddr <= curAddr + burstExt;
    end
  end

  assign addrOut = curAddr;
endmodule

// File: rtl/wrapAddrGen.sv
module wrapAddrGen
  import wag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STEP_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              wordAdv,
  input  logic              burstEnd,
  input  logic              regWrEn,
  input  logic              regProtEn,
  input  logic [CNT_W-1:0]  regWrData,
  input  logic [ADDR_W-1:0] beginAddr,
  input  logic [STEP_W-1:0] burstStep,
  input  logic [STEP_W-1:0] xferStep,
  input  logic [STEP_W-1:0] wrapStep,
  input  logic [CNT_W-1:0]  xferSize,
  output logic [ADDR_W-1:0] addrOut,
  output logic [CNT_W-1:0]  wrapSizeQ,
  output logic [CNT_W-1:0]  wrapCountQ
);
  wagStrobeT strb;

  wagCtrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .wordAdv(wordAdv),
    .burstEnd(burstEnd), .regWrEn(regWrEn), .regProtEn(regProtEn),
    .regWrData(regWrData), .xferSize(xferSize), .strb(strb),
    .wrapSizeQ(wrapSizeQ), .wrapCountQ(wrapCountQ)
  );

  wagDatapath #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .beginAddr(beginAddr),
    .burstStep(burstStep), .xferStep(xferStep), .wrapStep(wrapStep),
    .addrOut(addrOut)
  );
endmodule

// File: rtl/wagChecker.sv
module wagChecker #(
  parameter int ADDR_W = 32,
  parameter int STEP_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              wordAdv,
  input logic              burstEnd,
  input logic              regWrEn,
  input logic              regProtEn,
  input logic [ADDR_W-1:0] beginAddr,
  input logic [STEP_W-1:0] burstStep,
  input logic [STEP_W-1:0] xferStep,
  input logic [CNT_W-1:0]  xferSize,
  input logic [ADDR_W-1:0] addrOut,
  input logic [CNT_W-1:0]  wrapSizeQ,
  input logic [CNT_W-1:0]  wrapCountQ
);
  logic              armed;
  logic [ADDR_W-1:0] bExt;
  logic [ADDR_W-1:0] xExt;

  assign bExt = ADDR_W'($signed(burstStep));
  assign xExt = ADDR_W'($signed(xferStep));

  always_ff @(posedge clk) begin
    if (!rstN)      armed <= 1'b0;
    else if (start) armed <= (wrapSizeQ <= xferSize);
  end

  AST_PROT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regProtEn) |=> $stable(wrapSizeQ)); // R2
  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (addrOut == $past(beginAddr)) && (wrapCountQ == $past(wrapSizeQ))); // R3
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!start && !burstEnd && wordAdv) |=> addrOut == $past(addrOut) + $past(bExt)); // R4
  AST_COUNT_DEC: assert property (@(posedge clk) disable iff (!rstN)
    (!start && burstEnd && armed && wrapCountQ != '0) |=>
      (wrapCountQ == $past(wrapCountQ) - 1'b1) && (addrOut == $past(addrOut) + $past(xExt))); // R5
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (!start && burstEnd && armed && wrapCountQ == '0) |=> wrapCountQ == $past(wrapSizeQ)); // R6
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!start && !armed) |=> $stable(wrapCountQ)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!start && !burstEnd) |=> $stable(wrapCountQ)); // R8
endmodule

bind wrapAddrGen wagChecker #(.ADDR_W(ADDR_W), .STEP_W(STEP_W), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .wordAdv(wordAdv), .burstEnd(burstEnd),
  .regWrEn(regWrEn), .regProtEn(regProtEn), .beginAddr(beginAddr),
  .burstStep(burstStep), .xferStep(xferStep), .xferSize(xferSize),
  .addrOut(addrOut), .wrapSizeQ(wrapSizeQ), .wrapCountQ(wrapCountQ)
);

// File: tb/sim_wrapAddrGen.sv
`timescale 1ns/1ps
module sim_wrapAddrGen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, wordAdv = 1'b0, burstEnd = 1'b0;
  logic        regWrEn = 1'b0, regProtEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [31:0] beginAddr = '0;
  logic [15:0] burstStep = '0, xferStep = '0, wrapStep = '0, xferSize = '0;
  logic [31:0] addrOut;
  logic [15:0] wrapSizeQ, wrapCountQ;

  int nChk = 0, nFail = 0;
  logic [31:0] mAddr = '0, mBase = '0;
  logic [15:0] mSize = '0, mCount = '0;
  bit          mOn = 1'b0;

  always #2.5 clk = ~clk;

  wrapAddrGen u0 (
    .clk(clk), .rstN(rstN), .start(start), .wordAdv(wordAdv), .burstEnd(burstEnd),
    .regWrEn(regWrEn), .regProtEn(regProtEn), .regWrData(regWrData),
    .beginAddr(beginAddr), .burstStep(burstStep), .xferStep(xferStep),
    .wrapStep(wrapStep), .xferSize(xferSize), .addrOut(addrOut),
    .wrapSizeQ(wrapSizeQ), .wrapCountQ(wrapCountQ)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic modelStep();
    logic [15:0] oldSize = mSize;
    if (!rstN) begin
      mAddr = '0; mBase = '0; mSize = '0; mCount = '0; mOn = 1'b0;
      return;
    end
    if (start) begin
      mBase = beginAddr; mAddr = beginAddr; mCount = oldSize;
      mOn = (oldSize <= xferSize);
    end else if (burstEnd) begin
      if (mOn && mCount == 0) begin
        mBase = mBase + 32'($signed(wrapStep));
        mAddr = mBase; mCount = oldSize;
      end else begin
        mAddr = mAddr + 32'($signed(xferStep));
        if (mOn) mCount = mCount - 1;
      end
    end else if (wordAdv) begin
      mAddr = mAddr + 32'($signed(burstStep));
    end
    if (regWrEn && regProtEn) mSize = regWrData;
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    check(tag, "addr", addrOut, mAddr);
    check(tag, "size", {16'h0, wrapSizeQ}, {16'h0, mSize});
    check(tag, "count", {16'h0, wrapCountQ}, {16'h0, mCount});
  endtask

  task automatic wrSize(input logic [15:0] v, input bit prot, input string tag);
    regWrEn = 1'b1; regProtEn = prot; regWrData = v;
    cyc(tag);
    regWrEn = 1'b0; regProtEn = 1'b0;
  endtask

  task automatic doStart(input string tag);
    start = 1'b1; cyc(tag); start = 1'b0;
  endtask

  task automatic burst(input int words, input string tag);
    for (int w = 1; w < words; w++) begin
      wordAdv = 1'b1; cyc(tag);
    end
    wordAdv = 1'b0; burstEnd = 1'b1; cyc(tag); burstEnd = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    nChk++; nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc("R1"); cyc("R1");
    rstN = 1'b1;
    cyc("R1");
    check("R1", "addr", addrOut, 32'h0);
    check("R1", "count", {16'h0, wrapCountQ}, 32'h0);

    wrSize(16'h0005, 1'b0, "R2");
    check("R2", "size unprotected", {16'h0, wrapSizeQ}, 32'h0);
    wrSize(16'h0002, 1'b1, "R2");
    check("R2", "size protected", {16'h0, wrapSizeQ}, 32'h2);

    beginAddr = 32'h1000; burstStep = 16'd2; xferStep = 16'h10;
    wrapStep = 16'h100; xferSize = 16'd10;
    doStart("R3");
    check("R3", "addr", addrOut, 32'h1000);
    check("R3", "count", {16'h0, wrapCountQ}, 32'h2);
    burst(3, "R5");
    check("R5", "addr", addrOut, 32'h1014);
    check("R5", "count", {16'h0, wrapCountQ}, 32'h1);
    burst(3, "R5");
    burst(3, "R6");
    check("R6", "addr after wrap", addrOut, 32'h1100);
    check("R6", "count reload", {16'h0, wrapCountQ}, 32'h2);
    for (int i = 0; i < 7; i++) burst(3, "R6");
    for (int i = 0; i < 4; i++) cyc("R8");
    check("R8", "count held", {16'h0, wrapCountQ}, {16'h0, mCount});

    wrSize(16'h0000, 1'b1, "R2");
    burstStep = 16'hFFFC; xferStep = 16'hFFE0; wrapStep = 16'hFFC0;
    beginAddr = 32'h0000_2000;
    doStart("R3");
    burst(4, "R4");
    check("R4", "wrap every burst", addrOut, 32'h0000_1FC0);
    for (int i = 0; i < 4; i++) burst(2, "R6");

    wrSize(16'd20, 1'b1, "R2");
    burstStep = 16'd4; xferStep = 16'd8; wrapStep = 16'h40; beginAddr = 32'h3000;
    doStart("R7");
    for (int i = 0; i < 25; i++) burst(2, "R7");
    check("R7", "disabled count", {16'h0, wrapCountQ}, 32'd20);
    check("R7", "linear addr", addrOut, 32'h3000 + 25 * 12);

    wrSize(16'd10, 1'b1, "R7");
    doStart("R7");
    for (int i = 0; i < 12; i++) burst(2, "R7");
    check("R7", "equal keeps wrap", addrOut, 32'h3040 + 12);

    start = 1'b1; burstEnd = 1'b1; wordAdv = 1'b1; cyc("R9");
    start = 1'b0;
    check("R9", "start wins", addrOut, 32'h3000);
    cyc("R9");
    burstEnd = 1'b0; wordAdv = 1'b0;
    check("R9", "burst end wins", addrOut, 32'h3008);

    wrSize(16'hFFFF, 1'b0, "R2");
    check("R2", "ignored write", {16'h0, wrapSizeQ}, 32'd10);
    wrSize(16'hFFFF, 1'b1, "R10");
    xferSize = 16'hFFFF;
    doStart("R10");
    check("R10", "full count", {16'h0, wrapCountQ}, 32'hFFFF);
    burst(2, "R10");
    check("R10", "decrement", {16'h0, wrapCountQ}, 32'hFFFE);
    for (int i = 0; i < 3; i++) cyc("R8");

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule